// File: doc/BRIEF.md
# Repeating RTC Alarm Comparator

This block watches a running calendar clock held in packed BCD and raises an interrupt when the time reaches a programmed alarm point. Software programs four alarm bytes over a byte-wide register bus: seconds, minutes, hours and day of month. Bit 7 of each alarm byte is a "don't care" mask.

The masks, read as a prefix that starts at the date byte and moves down to seconds, choose how often the alarm repeats. The choices are once a month, once a day, once an hour, once a minute or once a second. The comparison is made only on cycles where the one-second tick is high, so a matching second yields exactly one interrupt pulse.

Each interrupt also sets a sticky alarm flag. Software reads the flag at offset 0 of the register window, and that read clears it. Offset 6 is a general interrupt-control byte that the block stores as written and returns on read.

Top module: `rtc_alarm`

## Requirements
- R1: After synchronous reset, `alarm_irq` and `alarm_flag` are 0, all alarm bytes and the control byte read back as 0x00, and the alarm is disarmed.
- R2: The register window is decoded as follows. Offset 2 holds the seconds alarm, offset 3 minutes, offset 4 hours, offset 5 date and offset 6 the control byte. Every accepted write stores all 8 bits. A read strobe returns data on `bus_rdata` one clock later. Unused offsets read 0x00, and writes to offset 0 have no effect.
- R3: Alarm writes are range-checked on masked BCD values, and a failing write is dropped, leaving the byte unchanged. Seconds and minutes are checked after `& 0x7F` and must be 0..59. Hours are checked after `& 0x3F` and must be 0..23. Date is checked after `& 0x1F` and must be 1..31.
- R4: With all four mask bits clear, the alarm fires when seconds, minutes, hours and date all equal the current time. The comparison uses the low 7, 7, 6 and 6 bits of each field.
- R5: With only the date mask set (date[7]=1, others 0), the alarm fires when hours, minutes and seconds match.
- R6: With the date and hour masks set and the minute and second masks clear, the alarm fires when minutes and seconds match.
- R7: With the date, hour and minute masks set and the second mask clear, the alarm fires when seconds match.
- R8: Every other mask pattern fires on every tick. This includes all four masks set, as well as any pattern where a lower mask is set while a higher one is clear.
- R9: A match is evaluated only in a cycle where `sec_tick` is 1. `alarm_irq` is then high for exactly the next single cycle. With `sec_tick` low, no interrupt is raised.
- R10: The alarm flag is bit 6 of offset 0. It is set together with the interrupt and is also visible on `alarm_flag`. A read of offset 0 returns the flag and then clears it, except that a new firing in the same cycle keeps it set.
- R11: The alarm is armed by the first accepted write to any alarm byte (offsets 2 to 5). While disarmed, no match fires. Reset disarms the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register window selected |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | WIN_AW | Offset within the register window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the read strobe |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| alarm_irq | output | 1 | One-cycle alarm interrupt pulse |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The bench builds the block with the default 4-bit window offset. At that width all 16 offsets can be reached, so the reserved offsets and the read-only flag offset are exercised next to the alarm and control bytes. A vector table covers every repeat rate with a hit and a near-miss, plus two out-of-order mask patterns. Directed tests then cover range limits, reset disarming and a flag read that coincides with a firing.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int BYTE_W   = 8;
    localparam int N_FIELDS = 4;
    localparam int FLAG_BIT = 6;

    // window offsets; alarm fields are contiguous starting at OFS_ALM_BASE
    localparam int OFS_FLAGS    = 0;
    localparam int OFS_ALM_BASE = 2;
    localparam int OFS_CTRL     = 6;

    // field index inside the alarm set
    localparam int IDX_SEC  = 0;
    localparam int IDX_MIN  = 1;
    localparam int IDX_HOUR = 2;
    localparam int IDX_DATE = 3;

    typedef enum logic [2:0] {
        RPT_MONTH,
        RPT_DAY,
        RPT_HOUR,
        RPT_MIN,
        RPT_SEC
    } rpt_e;

    typedef struct packed {
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } tfields_t;

    function automatic int unsigned bcd_val(input logic [7:0] b);
        return 32'(b[7:4]) * 10 + 32'(b[3:0]);
    endfunction

    function automatic logic field_ok(input int idx, input logic [7:0] v);
        logic ok;
        case (idx)
            IDX_SEC, IDX_MIN: ok = bcd_val(v & 8'h7F) <= 59;
            IDX_HOUR:         ok = bcd_val(v & 8'h3F) <= 23;
            default:          ok = (bcd_val(v & 8'h1F) >= 1) && (bcd_val(v & 8'h1F) <= 31);
        endcase
        return ok;
    endfunction

    // masks ordered {date, hour, min, sec}
    function automatic rpt_e rpt_decode(input logic [3:0] m);
        rpt_e r;
        case (m)
            4'b0000: r = RPT_MONTH;
            4'b1000: r = RPT_DAY;
            4'b1100: r = RPT_HOUR;
            4'b1110: r = RPT_MIN;
            default: r = RPT_SEC;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
#(
    parameter int WIN_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WIN_AW-1:0] addr,
    input  logic [7:0]        wdata,
    output tfields_t          alm,
    output logic [7:0]        ctrl,
    output logic              armed
);

    logic [7:0]          fld_q [N_FIELDS];
    logic [N_FIELDS-1:0] accept;
    logic [7:0]          ctrl_q;
    logic                armed_q;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
        localparam int OFS = OFS_ALM_BASE + i;
        assign accept[i] = wr_en && (addr == WIN_AW'(OFS)) && field_ok(i, wdata);

        always_ff @(posedge clk) begin
            if (rst)
                fld_q[i] <= '0;
            else if (accept[i])
                fld_q[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            if (wr_en && (addr == WIN_AW'(OFS_CTRL)))
                ctrl_q <= wdata;
            if (|accept)
                armed_q <= 1'b1;
        end
    end

    assign alm.sec  = fld_q[IDX_SEC];
    assign alm.min  = fld_q[IDX_MIN];
    assign alm.hour = fld_q[IDX_HOUR];
    assign alm.date = fld_q[IDX_DATE];
    assign ctrl     = ctrl_q;
    assign armed    = armed_q;

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  tfields_t alm,
    input  tfields_t now,
    output rpt_e     mode,
    output logic     hit
);

    logic eq_s, eq_m, eq_h, eq_d;

    always_comb begin
        eq_s = (alm.sec[6:0]  == now.sec[6:0]);
        eq_m = (alm.min[6:0]  == now.min[6:0]);
        eq_h = (alm.hour[5:0] == now.hour[5:0]);
        eq_d = (alm.date[5:0] == now.date[5:0]);
        mode = rpt_decode({alm.date[7], alm.hour[7], alm.min[7], alm.sec[7]});
        case (mode)
            RPT_MONTH: hit = eq_d && eq_h && eq_m && eq_s;
            RPT_DAY:   hit = eq_h && eq_m && eq_s;
            RPT_HOUR:  hit = eq_m && eq_s;
            RPT_MIN:   hit = eq_s;
            default:   hit = 1'b1;
        endcase
    end

endmodule

// File: rtl/rtc_alarm_event.sv
module rtc_alarm_event (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic clr,
    output logic irq,
    output logic flag
);

    logic irq_q, flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            irq_q <= fire;
            if (fire)
                flag_q <= 1'b1;
            else if (clr)
                flag_q <= 1'b0;
        end
    end

    assign irq  = irq_q;
    assign flag = flag_q;

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_alarm_pkg::*;
#(
    parameter int WIN_AW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIN_AW-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        cur_sec,
    input  logic [7:0]        cur_min,
    input  logic [7:0]        cur_hour,
    input  logic [7:0]        cur_date,
    input  logic              sec_tick,
    output logic              alarm_irq,
    output logic              alarm_flag
);

    tfields_t   fields_w;
    tfields_t   now_w;
    logic [7:0] ctrl_w;
    logic       armed_w;
    rpt_e       mode_w;
    logic       hit_w;
    logic       wr_en, rd_en, flag_rd;
    logic [7:0] rd_mux;
    logic [7:0] rdata_q;

    assign wr_en   = bus_sel && bus_wr;
    assign rd_en   = bus_sel && bus_rd;
    assign flag_rd = rd_en && (bus_addr == WIN_AW'(OFS_FLAGS));

    assign now_w.sec  = cur_sec;
    assign now_w.min  = cur_min;
    assign now_w.hour = cur_hour;
    assign now_w.date = cur_date;

    rtc_alarm_regs #(.WIN_AW(WIN_AW)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .alm   (fields_w),
        .ctrl  (ctrl_w),
        .armed (armed_w)
    );

    rtc_alarm_match match_i (
        .alm  (fields_w),
        .now  (now_w),
        .mode (mode_w),
        .hit  (hit_w)
    );

    rtc_alarm_event event_i (
        .clk  (clk),
        .rst  (rst),
        .fire (sec_tick && armed_w && hit_w),
        .clr  (flag_rd),
        .irq  (alarm_irq),
        .flag (alarm_flag)
    );

    always_comb begin
        rd_mux = '0;
        if (bus_addr == WIN_AW'(OFS_FLAGS))               rd_mux[FLAG_BIT] = alarm_flag;
        else if (bus_addr == WIN_AW'(OFS_ALM_BASE + IDX_SEC))  rd_mux = fields_w.sec;
        else if (bus_addr == WIN_AW'(OFS_ALM_BASE + IDX_MIN))  rd_mux = fields_w.min;
        else if (bus_addr == WIN_AW'(OFS_ALM_BASE + IDX_HOUR)) rd_mux = fields_w.hour;
        else if (bus_addr == WIN_AW'(OFS_ALM_BASE + IDX_DATE)) rd_mux = fields_w.date;
        else if (bus_addr == WIN_AW'(OFS_CTRL))           rd_mux = ctrl_w;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd_en)
            rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    logic unused_mode;
    assign unused_mode = ^mode_w;

endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk
    import rtc_alarm_pkg::*;
#(
    parameter int WIN_AW = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sec_tick,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [WIN_AW-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              alarm_irq,
    input logic              alarm_flag,
    input logic              armed,
    input logic [7:0]        sec_reg
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!alarm_irq && !alarm_flag && !armed));

    // R9
    irq_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> $past(sec_tick));

    // R10
    irq_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> alarm_flag);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_rd && bus_addr == WIN_AW'(OFS_FLAGS) && !sec_tick) |=> !alarm_flag);

    // R11
    irq_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> $past(armed));

    // R3
    bad_sec_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_addr == WIN_AW'(OFS_ALM_BASE + IDX_SEC)
         && bcd_val(bus_wdata & 8'h7F) > 59) |=> $stable(sec_reg));

endmodule

bind rtc_alarm rtc_alarm_chk #(.WIN_AW(WIN_AW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .sec_tick   (sec_tick),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .alarm_irq  (alarm_irq),
    .alarm_flag (alarm_flag),
    .armed      (armed_w),
    .sec_reg    (fields_w.sec)
);

// File: tb/rtc_alarm_tb.sv
module rtc_alarm_tb_top;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [7:0]    cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
    logic          sec_tick = 1'b0;
    logic          alarm_irq, alarm_flag;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rtc_alarm #(.WIN_AW(AW)) dut_i (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .sec_tick(sec_tick), .alarm_irq(alarm_irq), .alarm_flag(alarm_flag)
    );

    // {alarm sec, min, hour, date, time sec, min, hour, date, expected irq}
    localparam int NV = 11;
    localparam logic [64:0] VEC [NV] = '{
        {8'h30, 8'h15, 8'h12, 8'h21, 8'h30, 8'h15, 8'h12, 8'h21, 1'b1}, // R4 hit
        {8'h30, 8'h15, 8'h12, 8'h21, 8'h30, 8'h15, 8'h12, 8'h22, 1'b0}, // R4 date miss
        {8'h30, 8'h15, 8'h12, 8'h85, 8'h30, 8'h15, 8'h12, 8'h09, 1'b1}, // R5 hit
        {8'h30, 8'h15, 8'h12, 8'h85, 8'h30, 8'h15, 8'h13, 8'h09, 1'b0}, // R5 hour miss
        {8'h30, 8'h15, 8'h92, 8'h85, 8'h30, 8'h15, 8'h07, 8'h03, 1'b1}, // R6 hit
        {8'h30, 8'h15, 8'h92, 8'h85, 8'h30, 8'h16, 8'h07, 8'h03, 1'b0}, // R6 min miss
        {8'h30, 8'h95, 8'h92, 8'h85, 8'h30, 8'h44, 8'h07, 8'h03, 1'b1}, // R7 hit
        {8'h30, 8'h95, 8'h92, 8'h85, 8'h31, 8'h44, 8'h07, 8'h03, 1'b0}, // R7 sec miss
        {8'hB0, 8'h95, 8'h92, 8'h85, 8'h11, 8'h22, 8'h05, 8'h17, 1'b1}, // R8 all masked
        {8'hB0, 8'h15, 8'h12, 8'h21, 8'h01, 8'h59, 8'h23, 8'h09, 1'b1}, // R8 sec mask only
        {8'h30, 8'h15, 8'h92, 8'h21, 8'h02, 8'h40, 8'h01, 8'h04, 1'b1}  // R8 hour mask only
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = AW'(a);
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    // pulse tick one cycle; returns irq seen in the following cycle
    task automatic tick(output logic irq_seen);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        irq_seen = alarm_irq;
    endtask

    task automatic set_time(input logic [7:0] s, m, h, d);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic       irq;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", {7'b0, alarm_irq}, 8'h00);
        check("R1 flag", {7'b0, alarm_flag}, 8'h00);
        rd(2, v); check("R1 sec reg", v, 8'h00);
        rd(5, v); check("R1 date reg", v, 8'h00);
        rd(6, v); check("R1 ctrl reg", v, 8'h00);

        // R11 disarmed: zero alarm matches zero time yet no irq
        set_time(8'h00, 8'h00, 8'h00, 8'h00);
        tick(irq); check("R11 disarmed", {7'b0, irq}, 8'h00);

        // R2 control byte, unused offsets, flag offset write ignored
        wr(6, 8'hA5); rd(6, v); check("R2 ctrl", v, 8'hA5);
        wr(7, 8'h3C); rd(7, v); check("R2 unused", v, 8'h00);
        wr(0, 8'hFF); rd(0, v); check("R2 flags write ignored", v, 8'h00);
        tick(irq); check("R11 ctrl write does not arm", {7'b0, irq}, 8'h00);

        // R3 range checks
        wr(2, 8'h59); rd(2, v); check("R3 sec 59 ok", v, 8'h59);
        wr(2, 8'h60); rd(2, v); check("R3 sec 60 dropped", v, 8'h59);
        wr(3, 8'h5A); rd(3, v); check("R3 min 0x5A dropped", v, 8'h00);
        wr(3, 8'hD8); rd(3, v); check("R3 min masked ok", v, 8'hD8);
        wr(4, 8'h23); rd(4, v); check("R3 hour 23 ok", v, 8'h23);
        wr(4, 8'h24); rd(4, v); check("R3 hour 24 dropped", v, 8'h23);
        wr(5, 8'h00); rd(5, v); check("R3 date 0 dropped", v, 8'h00);
        wr(5, 8'h31); rd(5, v); check("R3 date 31 ok", v, 8'h31);

        // vector table: R4..R8 and R10 flag behaviour
        for (int i = 0; i < NV; i++) begin
            logic [64:0] e;
            e = VEC[i];
            wr(2, e[64:57]); wr(3, e[56:49]); wr(4, e[48:41]); wr(5, e[40:33]);
            set_time(e[32:25], e[24:17], e[16:9], e[8:1]);
            tick(irq);
            check($sformatf("R4-8 vector %0d irq", i), {7'b0, irq}, {7'b0, e[0]});
            @(negedge clk);
            check("R9 single pulse", {7'b0, alarm_irq}, 8'h00);
            rd(0, v);
            check("R10 flag read", v, e[0] ? 8'h40 : 8'h00);
            rd(0, v);
            check("R10 flag cleared", v, 8'h00);
        end

        // R9 no tick, no irq even with match (every-second pattern)
        wr(2, 8'hB0); wr(3, 8'h95); wr(4, 8'h92); wr(5, 8'h85);
        repeat (3) @(negedge clk);
        check("R9 no tick no irq", {7'b0, alarm_irq}, 8'h00);
        check("R9 no tick no flag", {7'b0, alarm_flag}, 8'h00);

        // R10 firing in the same cycle as a flag read keeps the flag
        @(negedge clk);
        sec_tick = 1'b1; bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = AW'(0);
        @(negedge clk);
        sec_tick = 1'b0; bus_sel = 1'b0; bus_rd = 1'b0;
        check("R10 read in firing cycle returns old", bus_rdata, 8'h00);
        check("R10 set wins", {7'b0, alarm_flag}, 8'h01);
        rd(0, v); check("R10 flag after collision", v, 8'h40);

        // R11 reset disarms and clears
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 flag after reset", {7'b0, alarm_flag}, 8'h00);
        set_time(8'h00, 8'h00, 8'h00, 8'h00);
        tick(irq); check("R11 reset disarms", {7'b0, irq}, 8'h00);
        rd(2, v); check("R1 sec after reset", v, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule